// File: doc/BRIEF.md
# Prescaled PWM Time-Base Counter

This block is the timing heart of a two-output PWM generator. A free-running module clock feeds a two-stage prescaler. One stage divides by a power of two and the other divides by one or by twice its code, so the counter steps once every D clocks, where D is the product of the two stages. A 16-bit counter then counts up, counts down, counts up and back down, or holds, as a two-bit mode field selects. It publishes its value together with single-cycle strobes when a step lands on zero or on the active period. Downstream action logic turns these into waveform edges.

The period is kept in two copies. A write lands either in a shadow copy, which is promoted to the active copy when the counter reaches zero, or directly in the active copy. A run-control field halts the counter at once, lets it finish the current cycle and rest at zero, or lets it run freely. All configuration arrives over a small synchronous write port: address 0 is the control word and address 1 is the period.

Top module: `pwm_timebase`

## Requirements
- R1: After synchronous reset, the counter is 0 and both strobes are low. The control state is up mode, shadow loading, both divider codes 0 and run code 00. Both period copies are 0. The counter stays at 0 until the run code is changed.
- R2: A write with wrAddr 0 loads the control word: bits [1:0] mode, bit 2 immediate-load, bits [5:3] coarse code n, bits [8:6] fine code m, bits [10:9] run code. A write with wrAddr 1 loads the period. Writes to addresses 2 and 3 change nothing.
- R3: The counter steps once every D = 2^n * (m==0 ? 1 : 2*m) clocks. When the run code leaves 00 at a write edge, the first step lands D clocks after that edge.
- R4: In mode 00 (up), each step adds one. A step taken at or above the active period returns the counter to 0.
- R5: In mode 01 (down), each step subtracts one. A step taken at 0 reloads the active period.
- R6: In mode 10 (up-down), the counter rises from 0 to the period and falls back to 0, turning at both ends. A full cycle is 2*period steps.
- R7: In mode 11 (freeze), the counter holds its value.
- R8: With the immediate-load bit at 0, a period write changes only the shadow copy. The shadow copy becomes active at the step that brings the counter to 0.
- R9: With the immediate-load bit at 1, a period write takes effect as the active period at once.
- R10: Run code 00 halts the counter. After the write edge that sets it, the value does not change.
- R11: Run code 01 lets the counter keep stepping until it reaches 0, where it rests.
- R12: zeroStb, and separately prdStb, is high for the one clock following a step whose new value is 0, and respectively equal to the active period.
- R13: A control write that changes n or m restarts the prescaler count, so the next step comes a full new interval after that write edge. The prescaler count is also held cleared while the run code is 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst | input | 1 | Synchronous active-high reset |
| wrEn | input | 1 | Write strobe for the register port |
| wrAddr | input | 2 | Register select: 0 control, 1 period |
| wrData | input | 16 | Write data |
| count | output | 16 | Current counter value |
| zeroStb | output | 1 | One-clock pulse after a step lands on zero |
| prdStb | output | 1 | One-clock pulse after a step lands on the active period |

## Verification
A prescaler count that is wrong shows up as a counter step one or more clocks early or late. This is visible at the first step after a start or a divider change, so the bench compares the counter against an arithmetic model on every clock, across several divisors. A wrong period copy or direction flag leaves the turnaround or wrap point in the wrong place. That error appears within one count cycle, at the sample where the counter should return to zero or reverse. A run or mode field that is decoded wrongly shows as motion where the counter should hold, caught within a few clocks of the write.

// File: rtl/ptb_pkg.sv
package ptb_pkg;

  typedef enum logic [1:0] {
    MODE_UP     = 2'b00,
    MODE_DOWN   = 2'b01,
    MODE_UPDN   = 2'b10,
    MODE_FREEZE = 2'b11
  } cntMode_e;

  typedef enum logic [1:0] {
    RUN_HALT    = 2'b00,
    RUN_STOPCYC = 2'b01,
    RUN_FREE    = 2'b10,
    RUN_FREEALT = 2'b11
  } runCtl_e;

  // Strobes handed from control to the datapath each clock
  typedef struct packed {
    logic     step;    // advance the counter this clock
    cntMode_e mode;    // counting rule
    logic     prdImm;  // period writes go straight to the active copy
    logic     prdWr;   // a period write is on the port this clock
  } tbCmd_t;

endpackage

// File: rtl/ptb_prescaler.sv
module ptb_prescaler #(
  parameter int N_W = 3,
  parameter int M_W = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           clear,
  input  logic           restart,
  input  logic [N_W-1:0] nCode,
  input  logic [M_W-1:0] mCode,
  output logic           tick
);
  localparam int DIV_W = (2 ** N_W - 1) + M_W + 1;

  logic [M_W:0]     fastDiv;
  logic [DIV_W-1:0] divisor;
  logic [DIV_W-1:0] psCnt;

  always_comb begin
    fastDiv = (mCode == '0) ? (M_W + 1)'(1) : {mCode, 1'b0};
    divisor = DIV_W'(fastDiv) << nCode;
    tick    = !clear && (psCnt >= divisor - DIV_W'(1));
  end

  always_ff @(posedge clk) begin
    if (rst || clear || restart) psCnt <= '0;
    else if (tick)               psCnt <= '0;
    else                         psCnt <= psCnt + DIV_W'(1);
  end

  // R3
  psRange_chk: assert property (@(posedge clk) disable iff (rst)
    psCnt < divisor);

endmodule

// File: rtl/ptb_ctrl.sv
module ptb_ctrl
  import ptb_pkg::*;
#(
  parameter int N_W    = 3,
  parameter int M_W    = 3,
  parameter int DATA_W = 16,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              tick,
  input  logic              isZero,
  output tbCmd_t            cmd,
  output logic [N_W-1:0]    nCode,
  output logic [M_W-1:0]    mCode,
  output logic              psClear,
  output logic              psRestart
);
  localparam int MODE_LSB = 0;
  localparam int IMM_POS  = 2;
  localparam int N_LSB    = 3;
  localparam int M_LSB    = N_LSB + N_W;
  localparam int RUN_LSB  = M_LSB + M_W;
  localparam int CTL_TOP  = RUN_LSB + 2;
  localparam int CTL_ADDR = 0;
  localparam int PRD_ADDR = 1;

  cntMode_e       modeQ;
  runCtl_e        runQ;
  logic           immQ;
  logic [N_W-1:0] nQ;
  logic [M_W-1:0] mQ;

  logic           ctlWr;
  logic           prdWr;
  logic [N_W-1:0] newN;
  logic [M_W-1:0] newM;
  logic           running;
  logic           unusedHigh;

  assign ctlWr      = wrEn && (wrAddr == ADDR_W'(CTL_ADDR));
  assign prdWr      = wrEn && (wrAddr == ADDR_W'(PRD_ADDR));
  assign newN       = wrData[N_LSB +: N_W];
  assign newM       = wrData[M_LSB +: M_W];
  assign unusedHigh = ^wrData[DATA_W-1:CTL_TOP];

  always_ff @(posedge clk) begin
    if (rst) begin
      modeQ <= MODE_UP;
      runQ  <= RUN_HALT;
      immQ  <= 1'b0;
      nQ    <= '0;
      mQ    <= '0;
    end else if (ctlWr) begin
      modeQ <= cntMode_e'(wrData[MODE_LSB +: 2]);
      runQ  <= runCtl_e'(wrData[RUN_LSB +: 2]);
      immQ  <= wrData[IMM_POS];
      nQ    <= newN;
      mQ    <= newM;
    end
  end

  always_comb begin
    running    = runQ[1] || ((runQ == RUN_STOPCYC) && !isZero);
    cmd.step   = tick && (modeQ != MODE_FREEZE) && running;
    cmd.mode   = modeQ;
    cmd.prdImm = immQ;
    cmd.prdWr  = prdWr;
    psClear    = (runQ == RUN_HALT);
    psRestart  = ctlWr && ({newN, newM} != {nQ, mQ});
    nCode      = nQ;
    mCode      = mQ;
  end

  // R11
  stopAtZero_chk: assert property (@(posedge clk) disable iff (rst)
    (runQ == RUN_STOPCYC && isZero) |=> isZero);

endmodule

// File: rtl/ptb_datapath.sv
module ptb_datapath
  import ptb_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  tbCmd_t           cmd,
  input  logic [CNT_W-1:0] wrData,
  output logic [CNT_W-1:0] count,
  output logic             zeroStb,
  output logic             prdStb,
  output logic             isZero
);
  logic [CNT_W-1:0] cntQ;
  logic [CNT_W-1:0] activeQ;
  logic [CNT_W-1:0] shadowQ;
  logic             downQ;
  logic             evtQ;
  logic [CNT_W-1:0] nextCnt;
  logic             nextDown;
  logic             shadowLoad;

  always_comb begin
    nextCnt  = cntQ;
    nextDown = downQ;
    case (cmd.mode)
      MODE_UP:   nextCnt = (cntQ >= activeQ) ? '0 : cntQ + CNT_W'(1);
      MODE_DOWN: nextCnt = (cntQ == '0) ? activeQ : cntQ - CNT_W'(1);
      MODE_UPDN: begin
        if (activeQ == '0) begin
          nextCnt  = '0;
          nextDown = 1'b0;
        end else if (cntQ == '0) begin
          nextCnt  = CNT_W'(1);
          nextDown = 1'b0;
        end else if (cntQ >= activeQ) begin
          nextCnt  = cntQ - CNT_W'(1);
          nextDown = 1'b1;
        end else if (downQ) begin
          nextCnt  = cntQ - CNT_W'(1);
        end else begin
          nextCnt  = cntQ + CNT_W'(1);
        end
      end
      default: nextCnt = cntQ;
    endcase
    shadowLoad = cmd.step && !cmd.prdImm && (nextCnt == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cntQ    <= '0;
      downQ   <= 1'b0;
      evtQ    <= 1'b0;
      activeQ <= '0;
      shadowQ <= '0;
    end else begin
      evtQ <= cmd.step;
      if (cmd.step) begin
        cntQ  <= nextCnt;
        downQ <= nextDown;
      end
      if (cmd.prdWr) shadowQ <= wrData;
      if (cmd.prdWr && cmd.prdImm) activeQ <= wrData;
      else if (shadowLoad)         activeQ <= shadowQ;
    end
  end

  assign count   = cntQ;
  assign isZero  = (cntQ == '0);
  assign zeroStb = evtQ && isZero;
  assign prdStb  = evtQ && (cntQ == activeQ);

  // R4
  upWrap_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd.step && cmd.mode == MODE_UP && cntQ >= activeQ) |=> (cntQ == '0));

  // R6
  updnStep_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd.step && cmd.mode == MODE_UPDN && activeQ != '0 && cntQ <= activeQ)
      |=> (cntQ == $past(cntQ) + CNT_W'(1) || cntQ + CNT_W'(1) == $past(cntQ)));

  // R7
  freezeHold_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd.mode == MODE_FREEZE) |=> (cntQ == $past(cntQ)));

  // R8
  activeLoad_chk: assert property (@(posedge clk) disable iff (rst)
    (activeQ != $past(activeQ)) |-> (cntQ == '0 || $past(cmd.prdWr && cmd.prdImm)));

endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
  import ptb_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 2,
  parameter int N_W    = 3,
  parameter int M_W    = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [CNT_W-1:0]  wrData,
  output logic [CNT_W-1:0]  count,
  output logic              zeroStb,
  output logic              prdStb
);
  tbCmd_t         cmd;
  logic [N_W-1:0] nCode;
  logic [M_W-1:0] mCode;
  logic           psClear;
  logic           psRestart;
  logic           tick;
  logic           isZero;

  ptb_ctrl #(.N_W(N_W), .M_W(M_W), .DATA_W(CNT_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .tick(tick), .isZero(isZero), .cmd(cmd), .nCode(nCode), .mCode(mCode),
    .psClear(psClear), .psRestart(psRestart)
  );

  ptb_prescaler #(.N_W(N_W), .M_W(M_W)) u_presc (
    .clk(clk), .rst(rst), .clear(psClear), .restart(psRestart),
    .nCode(nCode), .mCode(mCode), .tick(tick)
  );

  ptb_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rst(rst), .cmd(cmd), .wrData(wrData), .count(count),
    .zeroStb(zeroStb), .prdStb(prdStb), .isZero(isZero)
  );

  // R10
  haltHold_chk: assert property (@(posedge clk) disable iff (rst)
    psClear |=> $stable(count));

endmodule

// File: tb/pwm_timebase_tb.sv
`timescale 1ns/1ps
module pwm_timebase_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wrEn = 1'b0;
  logic [1:0]  wrAddr = 2'd0;
  logic [15:0] wrData = 16'd0;
  logic [15:0] count;
  logic        zeroStb;
  logic        prdStb;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;

  pwm_timebase u_dut (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .count(count), .zeroStb(zeroStb), .prdStb(prdStb)
  );

  function automatic int divOf(int n, int m);
    return (1 << n) * ((m == 0) ? 1 : 2 * m);
  endfunction

  function automatic logic [15:0] ctl(int mode, int imm, int n, int m, int run);
    return 16'(mode | (imm << 2) | (n << 3) | (m << 6) | (run << 9));
  endfunction

  function automatic int seqVal(int mode, int p, int j);
    int r;
    if (mode == 0) return j % (p + 1);
    if (mode == 1) return (j == 0) ? 0 : p - ((j - 1) % (p + 1));
    r = j % (2 * p);
    return (r <= p) ? r : 2 * p - r;
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  // called at a negedge; the write lands on the next rising edge
  task automatic wr(logic [1:0] a, logic [15:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; wrAddr = 2'd0; wrData = 16'd0;
  endtask

  // leaves the bench at the sample point just after the start edge
  task automatic startRun(int mode, int imm, int n, int m, int p);
    doReset();
    wr(2'd0, ctl(mode, 1, n, m, 0));
    wr(2'd1, 16'(p));
    wr(2'd0, ctl(mode, imm, n, m, 2));
  endtask

  task automatic sweep(int mode, int p, int n, int m);
    int d, per, total, j, e;
    string req;
    req = (mode == 0) ? "R4" : (mode == 1) ? "R5" : "R6";
    d = divOf(n, m);
    per = (mode == 2) ? 2 * p : p + 1;
    total = (2 * per + 1) * d;
    startRun(mode, 1, n, m, p);
    for (int k = 0; k <= total; k++) begin
      if (k > 0) @(negedge clk);
      j = k / d;
      e = seqVal(mode, p, j);
      chk({req, "/R3"}, $sformatf("count n=%0d m=%0d p=%0d k=%0d", n, m, p, k), count, e);
      chk("R12", $sformatf("zeroStb mode=%0d k=%0d", mode, k), zeroStb,
          (k > 0 && k % d == 0 && e == 0) ? 1 : 0);
      chk("R12", $sformatf("prdStb mode=%0d k=%0d", mode, k), prdStb,
          (k > 0 && k % d == 0 && e == p) ? 1 : 0);
    end
  endtask

  initial begin
    int nList[6] = '{0, 1, 0, 0, 2, 3};
    int mList[6] = '{0, 0, 1, 2, 3, 7};

    // R1 reset state and halted after reset
    doReset();
    chk("R1", "count after reset", count, 0);
    chk("R1", "zeroStb after reset", zeroStb, 0);
    chk("R1", "prdStb after reset", prdStb, 0);
    repeat (5) @(negedge clk);
    chk("R1", "count stays while halted", count, 0);

    // R3 R4 R5 R6 R12 sweeps over mode, period and divider codes
    for (int mode = 0; mode < 3; mode++)
      for (int pi = 0; pi < 2; pi++)
        for (int ci = 0; ci < 6; ci++)
          sweep(mode, (pi == 0) ? 1 : 3, nList[ci], mList[ci]);

    // R8 shadow loading: new period waits for the wrap
    startRun(0, 0, 0, 0, 3);
    repeat (2) @(negedge clk);
    wr(2'd1, 16'd6);
    chk("R8", "count at write", count, 3);
    chk("R12", "prdStb on old period", prdStb, 1);
    @(negedge clk);
    chk("R8", "wrap on old period", count, 0);
    repeat (6) @(negedge clk);
    chk("R8", "reaches new period", count, 6);
    @(negedge clk);
    chk("R8", "wraps after new period", count, 0);

    // R9 immediate loading
    startRun(0, 1, 0, 0, 3);
    repeat (2) @(negedge clk);
    wr(2'd1, 16'd6);
    chk("R9", "count at write", count, 3);
    @(negedge clk);
    chk("R9", "passes old period", count, 4);
    repeat (2) @(negedge clk);
    chk("R9", "count at new period", count, 6);
    chk("R12", "prdStb at new period", prdStb, 1);
    @(negedge clk);
    chk("R9", "wrap at new period", count, 0);

    // R10 halt
    startRun(0, 1, 0, 0, 5);
    repeat (2) @(negedge clk);
    wr(2'd0, ctl(0, 1, 0, 0, 0));
    chk("R10", "count at halt edge", count, 3);
    repeat (6) @(negedge clk);
    chk("R10", "count held", count, 3);
    chk("R10", "no zeroStb while halted", zeroStb, 0);
    chk("R10", "no prdStb while halted", prdStb, 0);

    // R11 stop at end of cycle
    startRun(0, 1, 0, 0, 5);
    repeat (2) @(negedge clk);
    wr(2'd0, ctl(0, 1, 0, 0, 1));
    chk("R11", "count at write", count, 3);
    repeat (3) @(negedge clk);
    chk("R11", "reaches zero", count, 0);
    chk("R11", "zeroStb at stop", zeroStb, 1);
    repeat (6) @(negedge clk);
    chk("R11", "rests at zero", count, 0);
    chk("R11", "no further zeroStb", zeroStb, 0);

    // R7 freeze
    startRun(0, 1, 0, 0, 5);
    repeat (2) @(negedge clk);
    wr(2'd0, ctl(3, 1, 0, 0, 2));
    chk("R7", "count at freeze edge", count, 3);
    repeat (5) @(negedge clk);
    chk("R7", "count frozen", count, 3);

    // R2 unused addresses change nothing
    startRun(0, 1, 0, 0, 5);
    repeat (2) @(negedge clk);
    wr(2'd2, 16'hFFFF);
    chk("R2", "count after addr 2 write", count, 3);
    wr(2'd3, 16'hFFFF);
    chk("R2", "count after addr 3 write", count, 4);
    @(negedge clk);
    chk("R2", "period unchanged", count, 5);
    chk("R2", "prdStb at old period", prdStb, 1);
    @(negedge clk);
    chk("R2", "wrap unchanged", count, 0);

    // R13 divider change restarts the prescaler
    startRun(0, 1, 2, 0, 100);
    repeat (5) @(negedge clk);
    chk("R13", "count before change", count, 1);
    wr(2'd0, ctl(0, 1, 1, 0, 2));
    chk("R13", "count at change edge", count, 1);
    @(negedge clk);
    chk("R13", "no early step", count, 1);
    @(negedge clk);
    chk("R13", "step one new interval later", count, 2);
    repeat (2) @(negedge clk);
    chk("R13", "new interval kept", count, 3);

    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

endmodule